// File: doc/BRIEF.md
# SMBus Host Status Register

This block holds the eight-bit status word of an SMBus host controller. The transaction engine reports what happened on the bus as one-cycle event pulses: a byte moved, a command finished, the host aborted, a collision, a device fault, or an alert from a slave. The block turns each pulse into a sticky flag that stays set until software writes a one to that bit. Bit 6 is a semaphore that software threads use to claim the controller: a read returns the bit's current value and then sets it. Bit 0 mirrors the engine's busy signal. An interrupt line rises whenever interrupts are enabled and any of the flags in bits 1 to 5 is set.

Software reaches the word through a flat register port. A write strobe carries data, and a read strobe returns data in the same cycle. Both strobes take effect only when the address equals the configured offset. The port has no handshake and no back-pressure: it accepts every strobe in the cycle it is presented. Event inputs are plain level-sampled pulses, with one register stage between an event and its flag.

Top module: `smb_host_status`

## Requirements
- R1: After `rst_n` is released, a read of the status offset returns 00h while `busy_in` is low.
- R2: A write to the status offset clears each of bits 7 and 5..1 whose data bit is 1. A data bit of 0 leaves the flag as it was.
- R3: Bit 7 sets on `xfer_byte`, unless `xfer_heartbeat` is high in the same cycle.
- R4: Bit 6 reads 0 on the first read after reset and is 1 after any read. Writing 1 to it makes the following read return 0. Writing 0 to it changes nothing. When a read and a write of 1 share a cycle, the write decides the new value.
- R5: Bit 5 sets on `alert_evt` only while `alert_is_gpio` is low. While `rsm_rst_n` is low, bit 5 is forced to 0, and this overrides a set in the same cycle.
- R6: Bit 4 sets on `kill_evt`, and bit 3 sets on `collision_evt`.
- R7: Bit 2 sets on any one of `bad_cmd_evt`, `unclaimed_evt` or `timeout_evt`.
- R8: Bit 1 sets on `cmd_done_evt` whatever the value of `intr_en`.
- R9: Bit 0 reads as `busy_in`, and writes have no effect on it.
- R10: `irq` is high exactly when `intr_en` is high and at least one of bits 5..1 holds 1. It falls in the cycle after the write that clears the last such bit.
- R11: If an event and a write-one clear hit the same flag in one cycle, the flag ends up set.
- R12: A read at any other offset returns 00h and does not touch the semaphore. A write at any other offset changes no bit.
- R13: `reg_rdata` shows the status as it stands before the clock edge that ends the read cycle. Events and side effects of that cycle appear in the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full reset, active low, asynchronous |
| rsm_rst_n | input | 1 | Resume-well reset, active low; clears the alert flag |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| xfer_byte | input | 1 | One byte moved in a block transfer |
| xfer_heartbeat | input | 1 | The current byte belongs to a heartbeat transmission |
| alert_evt | input | 1 | Alert line requests an interrupt |
| alert_is_gpio | input | 1 | Alert pin is configured as a GPIO |
| kill_evt | input | 1 | Host transaction aborted by kill |
| collision_evt | input | 1 | Bus collision detected |
| bad_cmd_evt | input | 1 | Illegal command field |
| unclaimed_evt | input | 1 | Host cycle not claimed by any device |
| timeout_evt | input | 1 | Device time-out |
| cmd_done_evt | input | 1 | Command terminated |
| busy_in | input | 1 | Engine is running a command |
| intr_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `ADDR_W` = 4 and `STS_OFFSET` = 0. With these values the decoder has only sixteen offsets, so the bench can hit both a neighbouring offset (1) and the top offset (15). It uses them to show that a miss returns zero and leaves the semaphore as it was. The narrow address does not change how any flag behaves, so every set, clear and priority case is exercised as it would be at full width.

// File: rtl/smb_sts_pkg.sv
package smb_sts_pkg;

  localparam int STS_W = 8;

  localparam int BIT_BUSY   = 0;
  localparam int BIT_INTR   = 1;
  localparam int BIT_DEVERR = 2;
  localparam int BIT_BUSERR = 3;
  localparam int BIT_FAILED = 4;
  localparam int BIT_ALERT  = 5;
  localparam int BIT_SEM    = 6;
  localparam int BIT_BYTE   = 7;

  // flags cleared by writing one
  localparam logic [STS_W-1:0] W1C_MASK = 8'b1011_1110;
  // flags that can raise the interrupt
  localparam logic [STS_W-1:0] IRQ_MASK = 8'b0011_1110;

  typedef struct packed {
    logic byte_xfer;
    logic heartbeat;
    logic alert;
    logic kill;
    logic collision;
    logic bad_cmd;
    logic unclaimed;
    logic timeout;
    logic cmd_done;
  } smb_evt_t;

endpackage

// File: rtl/smb_evt_map.sv
module smb_evt_map
  import smb_sts_pkg::*;
(
  input  smb_evt_t         evt,
  input  logic             alert_gpio,
  output logic [STS_W-1:0] set_vec
);

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_BYTE]   = evt.byte_xfer & ~evt.heartbeat;
    set_vec[BIT_ALERT]  = evt.alert & ~alert_gpio;
    set_vec[BIT_FAILED] = evt.kill;
    set_vec[BIT_BUSERR] = evt.collision;
    set_vec[BIT_DEVERR] = evt.bad_cmd | evt.unclaimed | evt.timeout;
    set_vec[BIT_INTR]   = evt.cmd_done;
  end

endmodule

// File: rtl/smb_sts_port.sv
module smb_sts_port
  import smb_sts_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STS_OFFSET = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [STS_W-1:0]  wdata,
  input  logic              rd,
  input  logic [STS_W-1:0]  sts,
  output logic              rd_hit,
  output logic [STS_W-1:0]  wr_ones,
  output logic [STS_W-1:0]  rdata
);

  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(STS_OFFSET);

  logic hit;

  assign hit     = (addr == OFF);
  assign rd_hit  = rd & hit;
  assign wr_ones = (wr & hit) ? wdata : '0;
  assign rdata   = rd_hit ? sts : '0;

endmodule

// File: rtl/smb_sticky_bit.sv
module smb_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic lvl_clr_i,
  output logic q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q_o <= 1'b0;
    else if (lvl_clr_i) q_o <= 1'b0;
    else if (set_i)     q_o <= 1'b1;
    else if (clr_i)     q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !lvl_clr_i) |=> q_o); // R11
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !lvl_clr_i) |=> !q_o); // R2
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !lvl_clr_i) |=> $stable(q_o)); // R2
  AST_LEVEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_clr_i |=> !q_o); // R5

endmodule

// File: rtl/smb_sem_bit.sv
module smb_sem_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_hit_i,
  input  logic wr_clr_i,
  output logic q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q_o <= 1'b0;
    else if (wr_clr_i) q_o <= 1'b0;
    else if (rd_hit_i) q_o <= 1'b1;
  end

  AST_SEM_TAKEN_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit_i && !wr_clr_i) |=> q_o); // R4
  AST_SEM_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_i |=> !q_o); // R4

endmodule

// File: rtl/smb_host_status.sv
module smb_host_status
  import smb_sts_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STS_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsm_rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  input  logic              xfer_byte,
  input  logic              xfer_heartbeat,
  input  logic              alert_evt,
  input  logic              alert_is_gpio,
  input  logic              kill_evt,
  input  logic              collision_evt,
  input  logic              bad_cmd_evt,
  input  logic              unclaimed_evt,
  input  logic              timeout_evt,
  input  logic              cmd_done_evt,
  input  logic              busy_in,
  input  logic              intr_en,
  output logic              irq
);

  smb_evt_t         evt;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] wr_ones;
  logic [STS_W-1:0] sts;
  logic             rd_hit;
  logic             unused_bits;

  assign evt = '{byte_xfer: xfer_byte, heartbeat: xfer_heartbeat,
                 alert: alert_evt, kill: kill_evt, collision: collision_evt,
                 bad_cmd: bad_cmd_evt, unclaimed: unclaimed_evt,
                 timeout: timeout_evt, cmd_done: cmd_done_evt};

  smb_evt_map u_map (
    .evt        (evt),
    .alert_gpio (alert_is_gpio),
    .set_vec    (set_vec)
  );

  smb_sts_port #(.ADDR_W(ADDR_W), .STS_OFFSET(STS_OFFSET)) u_port (
    .addr    (reg_addr),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .rd      (reg_rd),
    .sts     (sts),
    .rd_hit  (rd_hit),
    .wr_ones (wr_ones),
    .rdata   (reg_rdata)
  );

  assign sts[BIT_BUSY] = busy_in;

  for (genvar i = 1; i < STS_W; i++) begin : g_bit
    if (i == BIT_SEM) begin : g_sem
      smb_sem_bit u_sem (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit_i (rd_hit),
        .wr_clr_i (wr_ones[i]),
        .q_o      (sts[i])
      );
    end else begin : g_flag
      logic lvl_clr;
      if (i == BIT_ALERT) begin : g_rsm
        assign lvl_clr = ~rsm_rst_n;
      end else begin : g_norsm
        assign lvl_clr = 1'b0;
      end
      smb_sticky_bit u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec[i]),
        .clr_i     (wr_ones[i] & W1C_MASK[i]),
        .lvl_clr_i (lvl_clr),
        .q_o       (sts[i])
      );
    end
  end

  assign unused_bits = ^{set_vec[BIT_BUSY], set_vec[BIT_SEM], wr_ones[BIT_BUSY]};

  assign irq = intr_en & (|(sts & IRQ_MASK));

  AST_HEARTBEAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_heartbeat && !sts[BIT_BYTE]) |=> !sts[BIT_BYTE]); // R3
  AST_GPIO_NO_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_is_gpio && !sts[BIT_ALERT]) |=> !sts[BIT_ALERT]); // R5
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_en && cmd_done_evt) |=> (irq || !intr_en)); // R10
  AST_FAIL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    kill_evt |=> sts[BIT_FAILED]); // R6

endmodule

// File: tb/smb_host_status_test.sv
`timescale 1ns/1ps
module smb_host_status_test;

  localparam int AW = 4;
  // event vector layout used by the driver
  localparam int E_BYTE = 0, E_HB = 1, E_ALERT = 2, E_KILL = 3, E_COLL = 4,
                 E_BAD = 5, E_UNCL = 6, E_TO = 7, E_DONE = 8;

  logic clk = 0, rst_n = 0, rsm_rst_n = 1;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [8:0] ev = '0;
  logic alert_is_gpio = 0, busy_in = 0, intr_en = 0, irq;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // bench model of the status word
  logic [7:0] m = '0;
  logic       m_sem = 0;

  always #10 clk = ~clk;

  smb_host_status #(.ADDR_W(AW), .STS_OFFSET(0)) uut (
    .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .xfer_byte(ev[E_BYTE]), .xfer_heartbeat(ev[E_HB]), .alert_evt(ev[E_ALERT]),
    .alert_is_gpio(alert_is_gpio), .kill_evt(ev[E_KILL]),
    .collision_evt(ev[E_COLL]), .bad_cmd_evt(ev[E_BAD]),
    .unclaimed_evt(ev[E_UNCL]), .timeout_evt(ev[E_TO]),
    .cmd_done_evt(ev[E_DONE]), .busy_in(busy_in), .intr_en(intr_en), .irq(irq)
  );

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R13 unexpected read: got %h expected none", reg_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  // driver: one bus cycle plus one idle cycle, model updated alongside
  task automatic cycle(input logic [AW-1:0] a, input logic rd, input logic wr,
                       input logic [7:0] wd, input logic [8:0] e, input string tag);
    logic hit;
    hit = (a == 0);
    reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd; ev = e;
    if (rd) begin
      exp_q.push_back(hit ? {m[7], m_sem, m[5:1], busy_in} : 8'h00);
      tag_q.push_back(tag);
    end
    if (wr && hit) m = m & ~(wd & 8'hBE);
    if (wr && hit && wd[6]) m_sem = 0;
    else if (rd && hit) m_sem = 1;
    if (e[E_BYTE] && !e[E_HB]) m[7] = 1;
    if (e[E_ALERT] && !alert_is_gpio) m[5] = 1;
    if (e[E_KILL]) m[4] = 1;
    if (e[E_COLL]) m[3] = 1;
    if (e[E_BAD] || e[E_UNCL] || e[E_TO]) m[2] = 1;
    if (e[E_DONE]) m[1] = 1;
    if (!rsm_rst_n) m[5] = 0;
    @(posedge clk); #1;
    reg_rd = 0; reg_wr = 0; ev = '0;
    @(negedge clk);
    checks++;
    if (irq !== (intr_en & (|m[5:1]))) begin
      fails++;
      $display("FAIL R10 irq: got %b expected %b", irq, intr_en & (|m[5:1]));
    end
    @(posedge clk); #1;
  endtask

  task automatic rd0(input string tag);
    cycle('0, 1'b1, 1'b0, 8'h00, 9'h0, tag);
  endtask

  task automatic wr0(input logic [7:0] d);
    cycle('0, 1'b0, 1'b1, d, 9'h0, "");
  endtask

  task automatic evt(input logic [8:0] e);
    cycle('0, 1'b0, 1'b0, 8'h00, e, "");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    rd0("R1 reset value");
    rd0("R4 semaphore taken after first read");
    wr0(8'h00);
    rd0("R4 write zero keeps semaphore");
    wr0(8'h40);
    rd0("R4 write one releases semaphore");
    rd0("R4 read retakes semaphore");
    evt(9'h1 << E_BYTE);
    rd0("R3 byte done sets");
    wr0(8'h00);
    rd0("R2 write zero leaves flags");
    wr0(8'h80);
    rd0("R2 write one clears byte done");
    evt((9'h1 << E_BYTE) | (9'h1 << E_HB));
    rd0("R3 heartbeat byte ignored");
    alert_is_gpio = 1;
    evt(9'h1 << E_ALERT);
    rd0("R5 gpio mode blocks alert");
    alert_is_gpio = 0;
    evt(9'h1 << E_ALERT);
    rd0("R5 alert sets");
    rsm_rst_n = 0;
    evt(9'h1 << E_ALERT);
    rsm_rst_n = 1;
    rd0("R5 resume reset clears alert");
    evt((9'h1 << E_KILL) | (9'h1 << E_COLL));
    rd0("R6 failed and bus error set");
    wr0(8'h18);
    rd0("R2 failed and bus error cleared");
    for (int k = E_BAD; k <= E_TO; k++) begin
      evt(9'h1 << k);
      rd0("R7 device error cause");
      wr0(8'h04);
    end
    intr_en = 0;
    evt(9'h1 << E_DONE);
    rd0("R8 done sets intr with enable off");
    intr_en = 1;
    rd0("R10 enable raises irq");
    wr0(8'h02);
    rd0("R10 irq falls after last clear");
    evt(9'h1 << E_DONE);
    evt(9'h1 << E_ALERT);
    wr0(8'h02);
    rd0("R10 irq held by remaining alert");
    wr0(8'h20);
    intr_en = 0;
    busy_in = 1;
    rd0("R9 busy visible");
    wr0(8'h01);
    rd0("R9 write to busy ignored");
    busy_in = 0;
    rd0("R9 busy drops");
    cycle('0, 1'b0, 1'b1, 8'h10, 9'h1 << E_KILL, "");
    rd0("R11 set beats clear");
    wr0(8'h40);
    cycle(4'd1, 1'b1, 1'b0, 8'h00, 9'h0, "R12 other offset reads zero");
    cycle(4'd15, 1'b1, 1'b1, 8'hFF, 9'h0, "R12 top offset reads zero");
    rd0("R12 no change from other offsets");
    cycle('0, 1'b1, 1'b1, 8'h40, 9'h0, "R13 read returns pre-write value");
    rd0("R4 write one wins over same-cycle read");
    cycle('0, 1'b1, 1'b0, 8'h00, 9'h1 << E_COLL, "R13 read before event lands");
    rd0("R13 event visible next read");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule